// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block tracks which operating mode a small processor is in: full run, idle (core halted, peripherals still clocked) or sleep (every clock stopped). It also tracks which oscillator is clocking the device. It takes a two-bit source select, an idle-enable bit, a one-cycle sleep strobe, an enable bit for the secondary (low-power) oscillator, ready flags from the oscillators and a wake event. From these it produces the core and peripheral clock enables, a shutdown request for the primary oscillator, the source that the clock switcher should run from, and three status flags.

A change of source is not immediate. The controller enters a pending state and keeps the old source in use until the new one reports ready. The status flags describe the source that is actually running, never the one that was merely requested. A wake event returns the device to the run mode that the current select bits imply, through the same pending handshake. Select encoding: `00` primary, `01` secondary, `10` and `11` internal oscillator block. A switch to the internal block completes at once, because its RC output is always present.

Top module: `pm_mode_ctrl`

## Requirements
- R1: After a synchronous reset the block is in run mode on the primary source: `core_clk_en`=1, `periph_clk_en`=1, `pri_osc_off`=0, `clk_src_req`=00, `pri_active`=1, `int_stable`=0, `sec_active`=0.
- R2: With `sec_osc_en`=1, select `01` in run mode starts a switch to the secondary source. Once `sec_ready` is seen, `sec_active`=1, `pri_active`=0 and `pri_osc_off`=1.
- R3: If `sec_osc_en`=0 while select is `01` (in run mode or at a wake), the secondary source is not entered and the current source is kept.
- R4: While a switch is pending, `clk_src_req` shows the target, but the status flags keep showing the old source until the target's ready flag is sampled. The switch completes on the edge at which that ready flag is seen.
- R5: While a switch is pending, changes on `src_sel` are ignored until the switch completes.
- R6: A sleep strobe in run mode with `idle_en`=1 enters idle: `core_clk_en`=0, `periph_clk_en`=1.
- R7: A sleep strobe in run mode with `idle_en`=0 enters sleep. In sleep both enables are 0, `pri_osc_off`=1, `pri_active`=0 and `int_stable`=0, and `sec_active` stays set if the secondary was running.
- R8: The idle-or-sleep choice is taken from `idle_en` at each strobe, so successive strobes can enter different modes.
- R9: A wake in idle or sleep starts a switch to the source implied by the current select bits. The block is back in run mode one edge after that source is ready.
- R10: `int_stable` is set when `int_ready`=1 and the device runs from the internal block, or from the primary with `pri_is_internal`=1. In that last case `pri_active` and `int_stable` are both set. On the internal block with `int_ready`=0, no flag is set.
- R11: In run mode and during a switch both clock enables are 1. `pri_osc_off` is 1 whenever the primary neither runs nor is being started.
- R12: `pri_active` and `sec_active` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Requested source: 00 primary, 01 secondary, 1x internal |
| idle_en | input | 1 | 1 selects idle, 0 selects sleep at a strobe |
| sleep_req | input | 1 | One-cycle sleep strobe |
| sec_osc_en | input | 1 | Secondary oscillator enabled |
| pri_ready | input | 1 | Primary oscillator ready |
| sec_ready | input | 1 | Secondary oscillator ready |
| int_ready | input | 1 | Internal 8 MHz output stable |
| wake | input | 1 | Wake event |
| pri_is_internal | input | 1 | Primary source is configured as the internal block |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pri_osc_off | output | 1 | Request to shut down the primary oscillator |
| clk_src_req | output | 2 | Source the clock switcher should use |
| pri_active | output | 1 | Primary source is clocking the device |
| int_stable | output | 1 | Internal 8 MHz source is stable and in use |
| sec_active | output | 1 | Secondary source is clocking the device |

## Verification
A wrong mode register appears on the clock enables one edge after the strobe or wake that caused it. A wrong running-source register appears on the status flags and on `pri_osc_off` at the same edge. A target that is latched wrongly, or that moves while a switch is pending, shows on `clk_src_req` in the first cycle of the pending state. A switch that completes too early or too late shifts the flag change by whole cycles relative to the ready flag, so every check samples exactly one edge after the stimulus.

// File: rtl/pm_pkg.sv
// Shared types for the power-managed mode controller.
// Assumes a two-bit source select. The enum codes double as the select
// encoding driven towards the clock switcher.
package pm_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_PRI = 2'b00,
        SRC_SEC = 2'b01,
        SRC_INT = 2'b10
    } src_e;

    typedef enum logic [1:0] {
        M_RUN    = 2'b00,
        M_SWITCH = 2'b01,
        M_IDLE   = 2'b10,
        M_SLEEP  = 2'b11
    } mode_e;
endpackage

// File: rtl/pm_src_decode.sv
// Maps the raw select field to a source and decides whether it may be
// entered. Assumes both internal codes (1x) mean the internal block.
module pm_src_decode
    import pm_pkg::*;
(
    input  logic [SEL_W-1:0] src_sel,
    input  logic             sec_osc_en,
    output src_e             want,
    output logic             sel_ok
);
    // Decode the requested source from the select field.
    always_comb begin
        unique case (src_sel)
            2'b00:   want = SRC_PRI;
            2'b01:   want = SRC_SEC;
            default: want = SRC_INT;
        endcase
    end

    // Refuse the secondary source when its oscillator is not enabled.
    assign sel_ok = !((src_sel == 2'b01) && !sec_osc_en);
endmodule

// File: rtl/pm_mode_fsm.sv
// Mode state machine. Holds the mode, the source actually clocking the
// device, and the target of a pending switch. Assumes the ready flags are
// synchronous to clk. The internal block is always usable (RC output).
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sleep_req,
    input  logic  idle_en,
    input  logic  wake,
    input  src_e  want,
    input  logic  sel_ok,
    input  logic  pri_ready,
    input  logic  sec_ready,
    output mode_e mode,
    output src_e  active,
    output src_e  target
);
    logic tgt_ready;

    // Ready flag of the pending target.
    always_comb begin
        unique case (target)
            SRC_PRI: tgt_ready = pri_ready;
            SRC_SEC: tgt_ready = sec_ready;
            default: tgt_ready = 1'b1;
        endcase
    end

    // Mode, running source and switch target update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= M_RUN;
            active <= SRC_PRI;
            target <= SRC_PRI;
        end else begin
            unique case (mode)
                M_RUN: begin
                    if (sleep_req) begin
                        mode <= idle_en ? M_IDLE : M_SLEEP;
                    end else if (sel_ok && (want != active)) begin
                        target <= want;
                        mode   <= M_SWITCH;
                    end
                end
                M_SWITCH: begin
                    if (tgt_ready) begin
                        active <= target;
                        mode   <= M_RUN;
                    end
                end
                default: begin
                    if (wake) begin
                        target <= sel_ok ? want : active;
                        mode   <= M_SWITCH;
                    end
                end
            endcase
        end
    end

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && sleep_req && idle_en) |=> (mode == M_IDLE)); // R6
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && sleep_req && !idle_en) |=> (mode == M_SLEEP)); // R8
    AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SWITCH && !tgt_ready) |=> (mode == M_SWITCH && $stable(target))); // R5
    AST_SEC_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && !sleep_req && !sel_ok && active != SRC_SEC)
        |=> (mode == M_RUN && $stable(active))); // R3
endmodule

// File: rtl/pm_status.sv
// Output stage: clock enables, primary shutdown request, source request
// and status flags. All are derived from the FSM registers, so they move
// on the edge after the event that changed the state.
module pm_status
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  src_e             active,
    input  src_e             target,
    input  logic             int_ready,
    input  logic             pri_is_internal,
    output logic             core_clk_en,
    output logic             periph_clk_en,
    output logic             pri_osc_off,
    output logic [SEL_W-1:0] clk_src_req,
    output logic             pri_active,
    output logic             int_stable,
    output logic             sec_active
);
    logic asleep;
    logic pri_starting;

    assign asleep       = (mode == M_SLEEP);
    assign pri_starting = (mode == M_SWITCH) && (target == SRC_PRI);

    // Clock enables per mode.
    assign core_clk_en   = (mode == M_RUN) || (mode == M_SWITCH);
    assign periph_clk_en = !asleep;

    // Primary shutdown when it neither runs nor is being started.
    assign pri_osc_off = asleep || ((active != SRC_PRI) && !pri_starting);

    // Source for the switcher: target while pending, else the running one.
    assign clk_src_req = (mode == M_SWITCH) ? target : active;

    // Flags follow the source actually running.
    assign pri_active = (active == SRC_PRI) && !asleep;
    assign sec_active = (active == SRC_SEC);
    assign int_stable = int_ready && !asleep &&
                        ((active == SRC_INT) || ((active == SRC_PRI) && pri_is_internal));

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pri_active, sec_active})); // R12
    AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!core_clk_en && !periph_clk_en && pri_osc_off)); // R7
    AST_RUN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN) |-> (core_clk_en && periph_clk_en)); // R11
endmodule

// File: rtl/pm_mode_ctrl.sv
// Power-managed mode controller top. Decodes the select field, runs the
// mode FSM and drives enables and status flags. Oscillators and the
// interrupt logic that produces wake sit outside this block.
module pm_mode_ctrl
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             idle_en,
    input  logic             sleep_req,
    input  logic             sec_osc_en,
    input  logic             pri_ready,
    input  logic             sec_ready,
    input  logic             int_ready,
    input  logic             wake,
    input  logic             pri_is_internal,
    output logic             core_clk_en,
    output logic             periph_clk_en,
    output logic             pri_osc_off,
    output logic [SEL_W-1:0] clk_src_req,
    output logic             pri_active,
    output logic             int_stable,
    output logic             sec_active
);
    src_e  want;
    logic  sel_ok;
    mode_e mode;
    src_e  active;
    src_e  target;

    pm_src_decode u_dec (
        .src_sel    (src_sel),
        .sec_osc_en (sec_osc_en),
        .want       (want),
        .sel_ok     (sel_ok)
    );

    pm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .idle_en   (idle_en),
        .wake      (wake),
        .want      (want),
        .sel_ok    (sel_ok),
        .pri_ready (pri_ready),
        .sec_ready (sec_ready),
        .mode      (mode),
        .active    (active),
        .target    (target)
    );

    pm_status u_sts (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode            (mode),
        .active          (active),
        .target          (target),
        .int_ready       (int_ready),
        .pri_is_internal (pri_is_internal),
        .core_clk_en     (core_clk_en),
        .periph_clk_en   (periph_clk_en),
        .pri_osc_off     (pri_osc_off),
        .clk_src_req     (clk_src_req),
        .pri_active      (pri_active),
        .int_stable      (int_stable),
        .sec_active      (sec_active)
    );
endmodule

// File: tb/tb_pm_mode_ctrl.sv
`timescale 1ns/1ps
// Bench: vector table walked cycle by cycle, then directed tests.
module tb_pm_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] src_sel;
    logic       idle_en, sleep_req, sec_osc_en, pri_ready, sec_ready;
    logic       int_ready, wake, pri_is_internal;
    logic       core_clk_en, periph_clk_en, pri_osc_off, pri_active, int_stable, sec_active;
    logic [1:0] clk_src_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pm_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .idle_en(idle_en),
        .sleep_req(sleep_req), .sec_osc_en(sec_osc_en), .pri_ready(pri_ready),
        .sec_ready(sec_ready), .int_ready(int_ready), .wake(wake),
        .pri_is_internal(pri_is_internal), .core_clk_en(core_clk_en),
        .periph_clk_en(periph_clk_en), .pri_osc_off(pri_osc_off),
        .clk_src_req(clk_src_req), .pri_active(pri_active),
        .int_stable(int_stable), .sec_active(sec_active)
    );

    // Stimulus {sel[1:0], idle, sleep, sec_en, prdy, srdy, irdy, wake, cfg}
    // Expected {core, periph, pri_off, req[1:0], pri_act, int_st, sec_act}
    localparam int NV = 23;
    localparam logic [17:0] VEC [0:NV-1] = '{
        18'b00_0_0_1_1_1_0_0_0_1_1_0_00_1_0_0,
        18'b01_0_0_0_1_1_0_0_0_1_1_0_00_1_0_0,
        18'b01_0_0_1_1_0_0_0_0_1_1_0_01_1_0_0,
        18'b00_0_0_1_1_0_0_0_0_1_1_0_01_1_0_0,
        18'b01_0_0_1_1_1_0_0_0_1_1_1_01_0_0_1,
        18'b00_0_0_1_0_1_0_0_0_1_1_0_00_0_0_1,
        18'b00_0_0_1_0_1_0_0_0_1_1_0_00_0_0_1,
        18'b00_0_0_1_1_1_0_0_0_1_1_0_00_1_0_0,
        18'b00_1_1_1_1_1_0_0_0_0_1_0_00_1_0_0,
        18'b00_1_0_1_1_1_0_1_0_1_1_0_00_1_0_0,
        18'b00_0_0_1_1_1_0_0_0_1_1_0_00_1_0_0,
        18'b00_0_1_1_1_1_0_0_0_0_0_1_00_0_0_0,
        18'b00_0_0_1_0_1_0_1_0_1_1_0_00_1_0_0,
        18'b00_0_0_1_1_1_0_0_0_1_1_0_00_1_0_0,
        18'b10_0_0_1_1_1_1_0_0_1_1_0_10_1_0_0,
        18'b10_0_0_1_1_1_1_0_0_1_1_1_10_0_1_0,
        18'b10_0_0_1_1_1_0_0_0_1_1_1_10_0_0_0,
        18'b00_0_0_1_1_1_1_0_1_1_1_0_00_0_1_0,
        18'b00_0_0_1_1_1_1_0_1_1_1_0_00_1_1_0,
        18'b00_1_1_1_1_1_1_0_1_0_1_0_00_1_1_0,
        18'b01_0_0_1_1_1_1_1_1_1_1_0_01_1_1_0,
        18'b01_0_0_1_1_1_1_0_1_1_1_1_01_0_0_1,
        18'b01_0_1_1_1_1_1_0_1_0_0_1_01_0_0_1
    };

    function automatic string vec_tag(int i);
        case (i)
            0:                  return "R1";
            1:                  return "R3";
            2, 5, 6:            return "R4";
            3:                  return "R5";
            4:                  return "R2";
            7, 10, 13:          return "R11";
            8:                  return "R6";
            11:                 return "R7";
            9, 12, 20, 21:      return "R9";
            14, 15, 16, 17, 18: return "R10";
            default:            return "R8";
        endcase
    endfunction

    function automatic logic [7:0] observe();
        return {core_clk_en, periph_clk_en, pri_osc_off, clk_src_req,
                pri_active, int_stable, sec_active};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(logic [9:0] s);
        {src_sel, idle_en, sleep_req, sec_osc_en, pri_ready, sec_ready,
         int_ready, wake, pri_is_internal} = s;
    endtask

    // Apply one stimulus at the falling edge, sample at the next one.
    task automatic step(logic [9:0] s);
        drive(s);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    localparam logic [9:0] QUIET = 10'b00_0_0_1_1_1_0_0_0;
    localparam logic [7:0] RESET_EXP = 8'b1_1_0_00_1_0_0;

    initial begin
        drive(QUIET);
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1 reset state", observe(), RESET_EXP);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17:8]);
            check(vec_tag(i), observe(), VEC[i][7:0]);
            check("R12 exclusive flags", {7'd0, pri_active & sec_active}, 8'd0);
        end

        // R1: reset from secondary sleep returns to primary run.
        drive(QUIET);
        do_reset();
        check("R1 reset from sleep", observe(), RESET_EXP);

        // R3: wake with select 01 but oscillator disabled keeps primary.
        step(10'b00_1_1_1_1_1_0_0_0);
        step(10'b01_0_0_0_1_1_0_1_0);
        check("R3 wake refused target", observe(), 8'b1_1_0_00_1_0_0);
        step(10'b01_0_0_0_1_1_0_0_0);
        check("R3 wake refused result", observe(), 8'b1_1_0_00_1_0_0);

        // R8: two strobes in a row with different idle_en.
        step(10'b00_0_1_1_1_1_0_0_0);
        check("R8 first strobe sleep", {6'd0, core_clk_en, periph_clk_en}, 8'd0);
        step(10'b00_0_0_1_1_1_0_1_0);
        step(QUIET);
        step(10'b00_1_1_1_1_1_0_0_0);
        check("R8 second strobe idle", {6'd0, core_clk_en, periph_clk_en}, 8'd1);

        // R9: wake with select 10 lands on internal block in two edges.
        step(10'b10_0_0_1_1_1_1_1_0);
        check("R9 wake to internal pending", observe(), 8'b1_1_0_10_1_0_0);
        step(10'b10_0_0_1_1_1_1_0_0);
        check("R9 wake to internal done", observe(), 8'b1_1_1_10_0_1_0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule